// File: doc/BRIEF.md
# Quarter-Pel Bicubic Prediction Interpolator

This block builds an 8x8 motion-compensated prediction block at quarter-sample precision. A 4-bit mode picks one fractional offset for each axis. A rounding bit sets how the two passes round. The reference window is 11x11 pixels. It is streamed in one row per accepted beat, with all 11 pixels of a row side by side on one bus.

Each row is filtered horizontally as it arrives. The eight intermediate pixels of that row are clipped to 8 bits and stored. Once the 11th row is in, a vertical 4-tap filter runs over the stored rows. It emits the 64 prediction pixels in raster order, one per clock. A one-cycle done strobe follows the last pixel.

Window row k and column c hold the reference sample at block position (k-1, c-1). Each 4-tap filter therefore reads one sample before the centre and two after it.

Top module: `qpel_bicubic_mc`

## Requirements
- R1: While rst_ni is low and after its release, pix_vld_o, done_o and pix_o are all 0 until a block is produced.
- R2: A start_i seen while idle latches mode_i and rnd_i for the whole block. mode_i[1:0] is the horizontal fraction and mode_i[3:2] is the vertical fraction, with 0 = integer, 1 = quarter, 2 = half, 3 = three-quarter.
- R3: Fraction 0 on an axis copies the centre sample through that pass unchanged.
- R4: For a quarter fraction with samples a, b, c, d at offsets -1, 0, +1, +2, the result is (53b + 18c - 4a - 3d + 32 - r) arithmetically shifted right by 6.
- R5: For a half fraction, the result is (9b + 9c - a - d + 8 - r) arithmetically shifted right by 4.
- R6: For a three-quarter fraction, the result is (18b + 53c - 3a - 4d + 32 - r) arithmetically shifted right by 6.
- R7: The horizontal pass uses r = rnd, and the vertical pass uses r = 1 - rnd.
- R8: Every intermediate result and every output pixel is clamped to the range 0..255.
- R9: Window rows are taken top to bottom, one per cycle in which row_vld_i is high during loading. Column c sits at row_i[8c+7:8c]. Idle cycles between rows are allowed.
- R10: After the 11th row, exactly 64 pixels appear with pix_vld_o high on consecutive cycles, in raster order (row by row, left to right). Output pixel (y, x) uses intermediate rows y..y+3 at column x.
- R11: done_o is high for exactly one cycle, the cycle right after the last valid pixel, and never together with pix_vld_o.
- R12: start_i while a block is being loaded or emitted, and row_vld_i outside loading, have no effect on the pixels produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block (accepted when idle) |
| mode_i | input | 4 | [1:0] horizontal fraction, [3:2] vertical fraction |
| rnd_i | input | 1 | Rounding control |
| row_vld_i | input | 1 | A window row is present on row_i |
| row_i | input | 88 | 11 reference pixels, column c at bits 8c+7:8c |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_o | output | 8 | Prediction pixel, raster order |
| done_o | output | 1 | One-cycle strobe after the 64th pixel |

## Verification
The assertions check the framing of the output on every cycle: the pixel count per block never exceeds 64, valid ends only into a done strobe, done is a single cycle that follows a valid pixel and carries a count of exactly 64, and row writes stay inside the window. Pixel values are checked only by the bench scenarios. These cover the kernel arithmetic for all sixteen modes, the complementary rounding between the passes, clipping at both ends of the range, the placement of the window around the block, and immunity to stray start and row strobes.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  localparam int FRAC_W = 2;
  localparam int MODE_W = 2 * FRAC_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  typedef enum logic [FRAC_W-1:0] {
    FR_INT  = 2'd0,
    FR_QTR  = 2'd1,
    FR_HALF = 2'd2,
    FR_3QTR = 2'd3
  } frac_e;
endpackage

// File: rtl/qpel_tap4.sv
module qpel_tap4 import qpel_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]  s_m1_i,
  input  logic [PIX_W-1:0]  s_0_i,
  input  logic [PIX_W-1:0]  s_p1_i,
  input  logic [PIX_W-1:0]  s_p2_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              r_i,
  output logic [PIX_W-1:0]  y_o
);
  localparam int MAXV = (1 << PIX_W) - 1;

  int a, b, c, d, r, acc, res;

  always_comb begin
    a = int'(s_m1_i);
    b = int'(s_0_i);
    c = int'(s_p1_i);
    d = int'(s_p2_i);
    r = int'(r_i);
    unique case (frac_e'(frac_i))
      FR_QTR:  acc = (53 * b + 18 * c - 4 * a - 3 * d + 32 - r) >>> 6;
      FR_HALF: acc = (9 * b + 9 * c - a - d + 8 - r) >>> 4;
      FR_3QTR: acc = (18 * b + 53 * c - 3 * a - 4 * d + 32 - r) >>> 6;
      default: acc = b;
    endcase
    if (acc < 0)         res = 0;
    else if (acc > MAXV) res = MAXV;
    else                 res = acc;
    y_o = res[PIX_W-1:0];
  end
endmodule

// File: rtl/qpel_hrow.sv
module qpel_hrow import qpel_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  localparam int WIN  = BLK + 3
) (
  input  logic [WIN*PIX_W-1:0] row_i,
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic                 r_i,
  output logic [BLK*PIX_W-1:0] row_o
);
  for (genvar i = 0; i < BLK; i++) begin : g_col
    // output column i is centred on window column i+1
    qpel_tap4 #(.PIX_W(PIX_W)) u_tap (
      .s_m1_i (row_i[(i+0)*PIX_W +: PIX_W]),
      .s_0_i  (row_i[(i+1)*PIX_W +: PIX_W]),
      .s_p1_i (row_i[(i+2)*PIX_W +: PIX_W]),
      .s_p2_i (row_i[(i+3)*PIX_W +: PIX_W]),
      .frac_i (frac_i),
      .r_i    (r_i),
      .y_o    (row_o[i*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/qpel_seq.sv
module qpel_seq import qpel_pkg::*; #(
  parameter int BLK = 8,
  localparam int WIN   = BLK + 3,
  localparam int ROW_W = $clog2(WIN),
  localparam int IDX_W = $clog2(BLK * BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             row_vld_i,
  output logic             ld_o,
  output logic             wr_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic             emit_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             fin_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(WIN - 1);
  localparam logic [IDX_W-1:0] PIX_LAST = IDX_W'(BLK * BLK - 1);

  seq_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] pix_q;

  assign ld_o      = (state_q == ST_IDLE) && start_i;
  assign wr_o      = (state_q == ST_LOAD) && row_vld_i;
  assign wr_row_o  = row_q;
  assign emit_o    = (state_q == ST_EMIT);
  assign pix_idx_o = pix_q;
  assign fin_o     = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      pix_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          row_q   <= '0;
        end
        ST_LOAD: if (row_vld_i) begin
          if (row_q == ROW_LAST) begin
            state_q <= ST_EMIT;
            pix_q   <= '0;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_EMIT: begin
          if (pix_q == PIX_LAST) state_q <= ST_FIN;
          else                   pix_q   <= pix_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  row_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (wr_row_o <= ROW_LAST));
endmodule

// File: rtl/qpel_bicubic_mc.sv
module qpel_bicubic_mc import qpel_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  localparam int WIN   = BLK + 3,
  localparam int ROW_W = $clog2(WIN),
  localparam int IDX_W = $clog2(BLK * BLK),
  localparam int COL_W = $clog2(BLK)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic                 rnd_i,
  input  logic                 row_vld_i,
  input  logic [WIN*PIX_W-1:0] row_i,
  output logic                 pix_vld_o,
  output logic [PIX_W-1:0]     pix_o,
  output logic                 done_o
);
  localparam int CNT_W = $clog2(BLK * BLK + 1);

  logic             ld, wr, emit, fin;
  logic [ROW_W-1:0] wr_row;
  logic [IDX_W-1:0] pix_idx;
  logic [MODE_W-1:0] mode_q;
  logic              rnd_q;

  logic [BLK*PIX_W-1:0] hrow;
  logic [BLK*PIX_W-1:0] mid_q [WIN];

  qpel_seq #(.BLK(BLK)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .row_vld_i (row_vld_i),
    .ld_o      (ld),
    .wr_o      (wr),
    .wr_row_o  (wr_row),
    .emit_o    (emit),
    .pix_idx_o (pix_idx),
    .fin_o     (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rnd_q  <= 1'b0;
    end else if (ld) begin
      mode_q <= mode_i;
      rnd_q  <= rnd_i;
    end
  end

  qpel_hrow #(.PIX_W(PIX_W), .BLK(BLK)) u_hrow (
    .row_i  (row_i),
    .frac_i (mode_q[FRAC_W-1:0]),
    .r_i    (rnd_q),
    .row_o  (hrow)
  );

  always_ff @(posedge clk_i) begin
    if (wr) mid_q[wr_row] <= hrow;
  end

  // vertical pass: one pixel per cycle
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] top;
  logic [PIX_W-1:0] vs [4];
  logic [PIX_W-1:0] vout;

  assign col = pix_idx[COL_W-1:0];
  assign top = ROW_W'(pix_idx[IDX_W-1:COL_W]);

  for (genvar k = 0; k < 4; k++) begin : g_vtap
    logic [BLK*PIX_W-1:0] rsel;
    assign rsel  = mid_q[top + ROW_W'(k)];
    assign vs[k] = rsel[col*PIX_W +: PIX_W];
  end

  qpel_tap4 #(.PIX_W(PIX_W)) u_vtap (
    .s_m1_i (vs[0]),
    .s_0_i  (vs[1]),
    .s_p1_i (vs[2]),
    .s_p2_i (vs[3]),
    .frac_i (mode_q[MODE_W-1:FRAC_W]),
    .r_i    (~rnd_q),
    .y_o    (vout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_vld_o <= 1'b0;
      pix_o     <= '0;
      done_o    <= 1'b0;
    end else begin
      pix_vld_o <= emit;
      done_o    <= fin;
      if (emit) pix_o <= vout;
    end
  end

  // checker state: valid pixels seen in the current block
  logic [CNT_W-1:0] vld_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vld_cnt_q <= '0;
    else if (done_o)    vld_cnt_q <= '0;
    else if (pix_vld_o) vld_cnt_q <= vld_cnt_q + 1'b1;
  end

  // R10
  pix_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> (vld_cnt_q < CNT_W'(BLK * BLK)));
  // R10
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_vld_o) |-> done_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_after_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(pix_vld_o) && !pix_vld_o));
  // R11
  done_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vld_cnt_q == CNT_W'(BLK * BLK)));
endmodule

// File: tb/tb_qpel_bicubic_mc.sv
module tb_qpel_bicubic_mc;
  localparam int BLK = 8;
  localparam int WIN = BLK + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] mode_i = '0;
  logic rnd_i = 1'b0;
  logic row_vld_i = 1'b0;
  logic [WIN*8-1:0] row_i = '0;
  logic pix_vld_o, done_o;
  logic [7:0] pix_o;

  always #2 clk = ~clk;

  qpel_bicubic_mc dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .rnd_i(rnd_i), .row_vld_i(row_vld_i), .row_i(row_i),
    .pix_vld_o(pix_vld_o), .pix_o(pix_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0, rcv = 0;
  int win [WIN][WIN];
  int expv [BLK][BLK];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kfilt(int a, int b, int c, int d, int f, int r);
    int v;
    case (f)
      1: v = (53*b + 18*c - 4*a - 3*d + 32 - r) >>> 6;
      2: v = (9*b + 9*c - a - d + 8 - r) >>> 4;
      3: v = (18*b + 53*c - 3*a - 4*d + 32 - r) >>> 6;
      default: v = b;
    endcase
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic build(input int kind);
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++)
        case (kind)
          1: win[y][x] = 255;
          2: win[y][x] = ((x % 4) == 1 || (x % 4) == 2) ? 255 : 0;
          3: win[y][x] = ((x % 4) == 1 || (x % 4) == 2) ? 0 : 255;
          4: win[y][x] = ((y % 4) == 1 || (y % 4) == 2) ? 255 : 0;
          5: win[y][x] = ((y % 4) == 1 || (y % 4) == 2) ? 0 : 255;
          6: win[y][x] = 0;
          default: win[y][x] = int'($urandom_range(0, 255));
        endcase
  endtask

  task automatic expect_blk(input int mode, input int rnd);
    int mid [WIN][BLK];
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < BLK; x++)
        mid[y][x] = kfilt(win[y][x], win[y][x+1], win[y][x+2], win[y][x+3], mode & 3, rnd);
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++)
        expv[y][x] = kfilt(mid[y][x], mid[y+1][x], mid[y+2][x], mid[y+3][x], (mode >> 2) & 3, 1 - rnd);
  endtask

  task automatic run_blk(input int mode, input int rnd, input int kind, input bit noise);
    build(kind);
    expect_blk(mode, rnd);
    rcv = 0;
    fork
      begin : drv
        @(negedge clk);
        start_i = 1'b1; mode_i = 4'(mode); rnd_i = rnd[0];
        @(negedge clk);
        start_i = 1'b0;
        mode_i = 4'($urandom); rnd_i = 1'($urandom);
        for (int y = 0; y < WIN; y++) begin
          int gap = noise ? int'($urandom_range(0, 2)) : 0;
          for (int g = 0; g < gap; g++) begin
            row_vld_i = 1'b0;
            row_i = {$urandom, $urandom, $urandom};
            start_i = 1'($urandom);  // R12: start while loading
            @(negedge clk);
          end
          start_i = 1'b0;
          row_vld_i = 1'b1;
          for (int x = 0; x < WIN; x++) row_i[8*x +: 8] = 8'(win[y][x]);
          @(negedge clk);
        end
        row_vld_i = 1'b0;
        while (noise && rcv < 56) begin  // R12: stray strobes while emitting
          row_vld_i = 1'($urandom);
          start_i = 1'($urandom);
          row_i = {$urandom, $urandom, $urandom};
          @(negedge clk);
        end
        row_vld_i = 1'b0;
        start_i = 1'b0;
      end
      begin : mon
        bit prev_v = 1'b0;
        forever begin
          @(negedge clk);
          if (pix_vld_o) begin
            if (rcv < 64) begin
              // R3 R4 R5 R6 R7 R8 R9 R10: pixel value in raster order
              chk(int'(pix_o) == expv[rcv / 8][rcv % 8], "R10 pixel", int'(pix_o), expv[rcv / 8][rcv % 8]);
            end
            rcv++;
          end
          if (done_o) begin
            chk(rcv == 64, "R10 pixel count", rcv, 64);
            chk(prev_v && !pix_vld_o, "R11 done timing", int'(prev_v), 1);
            break;
          end
          prev_v = pix_vld_o;
        end
      end
    join
    @(negedge clk);
    chk(done_o == 1'b0, "R11 done width", int'(done_o), 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        chk(1'b0, "watchdog", wd, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1
    chk(pix_vld_o == 1'b0, "R1 valid in reset", int'(pix_vld_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(pix_vld_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", int'({pix_vld_o, done_o}), 0);
    chk(pix_o == 8'd0, "R1 pixel after reset", int'(pix_o), 0);

    // R12: rows with no start are ignored
    for (int i = 0; i < 20; i++) begin
      row_vld_i = 1'b1; row_i = {$urandom, $urandom, $urandom};
      @(negedge clk);
      chk(pix_vld_o == 1'b0, "R12 rows while idle", int'(pix_vld_o), 0);
    end
    row_vld_i = 1'b0;

    // R3 integer pass-through, R2 field positions
    run_blk(4'h0, 0, 0, 1'b0);
    run_blk(4'h1, 0, 0, 1'b0);  // R4 horizontal only
    run_blk(4'h4, 1, 0, 1'b0);  // R4 vertical only
    run_blk(4'h2, 1, 0, 1'b0);  // R5
    run_blk(4'h8, 0, 0, 1'b0);
    run_blk(4'h3, 0, 0, 1'b0);  // R6
    run_blk(4'hC, 1, 0, 1'b0);
    // R8 clamping at both ends
    run_blk(4'h1, 0, 2, 1'b0);
    run_blk(4'h1, 0, 3, 1'b0);
    run_blk(4'h3, 1, 2, 1'b0);
    run_blk(4'h4, 0, 4, 1'b0);
    run_blk(4'hC, 1, 5, 1'b0);
    run_blk(4'hA, 0, 1, 1'b0);
    run_blk(4'hF, 1, 6, 1'b0);
    // R7: same window under both rounding settings
    run_blk(4'hA, 0, 0, 1'b0);
    run_blk(4'hA, 1, 0, 1'b0);
    // all modes, random windows, stalls and stray strobes (R9 R12)
    for (int m = 0; m < 16; m++) begin
      run_blk(m, int'($urandom_range(0, 1)), 0, 1'b1);
    end
    for (int i = 0; i < 16; i++) begin
      run_blk(int'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
              int'($urandom_range(0, 6)), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule